// File: doc/BRIEF.md
# SPI Serial Clock Rate Divider

This block generates the serial clock timing of an SPI master from the bus clock. An 8-bit rate register holds two fields. One is a linear preselect term. The other is a power-of-two selection term. Together they set a divisor of `(pre + 1) * 2^(sel + 1)` bus clocks per serial clock period. While the SPI controller holds `run_en` high, the block emits a single-cycle `half_tick` strobe every half period, and the controller toggles the serial clock on each strobe.

The register can be written and read at any time. In master mode, a write that changes either rate field raises a one-cycle `xfer_abort` pulse. The controller uses this pulse to drop any transfer in progress and go idle. The divider restarts its count on the same cycle. Shifting, slave select and the transfer sequencing belong to the surrounding controller.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `xfer_abort` is low. With `run_en` high, `half_tick` then fires on every enabled bus clock, which gives a divisor of 2.
- R2: A write with `wr_en` high stores `wr_data[6:4]` as the preselect `pre` and `wr_data[2:0]` as the selection `sel`. `rd_data` returns them at the same bit positions from the cycle after the write.
- R3: `wr_data[7]` and `wr_data[3]` are ignored, and `rd_data[7]` and `rd_data[3]` always read 0.
- R4: With `run_en` held high and no abort, `half_tick` fires once every `H = (pre + 1) * 2^sel` bus clocks. The first strobe comes on the H-th enabled cycle.
- R5: The largest setting, pre=7 and sel=7, gives H=1024 (divisor 2048) and works without counter overflow.
- R6: While `run_en` is low the counter is held cleared and `half_tick` stays low. When `run_en` rises again, counting restarts from zero.
- R7: A write in master mode (`master_mode`=1) that changes `pre` or `sel` drives `xfer_abort` high for exactly the one cycle that follows the write.
- R8: A write that leaves both fields unchanged, or any write with `master_mode`=0, leaves `xfer_abort` low.
- R9: In the abort cycle `half_tick` is low and the counter is cleared, so the next strobe comes H enabled cycles after the abort cycle.
- R10: Without a write, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| master_mode | input | 1 | High when the SPI operates as master |
| run_en | input | 1 | Divider enable from the SPI controller |
| half_tick | output | 1 | Half-period serial clock toggle strobe |
| xfer_abort | output | 1 | One-cycle abort pulse after a master-mode rate change |

## Verification
If the rate fields are stored wrongly, `rd_data` shows it in the cycle after the write. The spacing of the very next strobe is also wrong, up to H cycles later. If the counter is not cleared on an abort or on a low `run_en`, the next `half_tick` comes early or late, which shows within one half period. A faulty change detector either misses the abort pulse or produces a spurious one on the cycle right after the write.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int PRE_W = 3;
  localparam int SEL_W = 3;
  localparam int REG_W = PRE_W + SEL_W + 2;
  localparam int CNT_W = PRE_W + (1 << SEL_W);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
  } rate_cfg_t;

  // bus clocks between two toggle strobes (half the serial period)
  function automatic int unsigned half_cycles(input int unsigned pre, input int unsigned sel);
    return (pre + 1) << sel;
  endfunction

  // bus clocks per full serial clock period
  function automatic int unsigned full_divisor(input int unsigned pre, input int unsigned sel);
    return (pre + 1) << (sel + 1);
  endfunction
endpackage

// File: rtl/spi_rate_reg.sv
module spi_rate_reg
  import spi_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             master_mode,
  output logic [REG_W-1:0] rd_data,
  output rate_cfg_t        cfg,
  output logic             abort_q
);
  localparam int PRE_LO = SEL_W + 1;
  localparam int PRE_HI = SEL_W + PRE_W;

  rate_cfg_t cfg_q;
  rate_cfg_t cfg_wr;
  logic      fields_differ;
  logic      abort_evt;

  assign cfg_wr.pre    = wr_data[PRE_HI:PRE_LO];
  assign cfg_wr.sel    = wr_data[SEL_W-1:0];
  assign fields_differ = (cfg_wr != cfg_q);
  assign abort_evt     = wr_en && master_mode && fields_differ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_wr;
      abort_q <= abort_evt;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = {1'b0, cfg_q.pre, 1'b0, cfg_q.sel};

  // R7: an abort is always preceded by a master-mode write
  p_abort_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(wr_en && master_mode));
  // R8: slave-mode writes never abort
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !master_mode) |=> !abort_q);
  // R10: register content is stable without a write
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_en,
  input  logic      abort,
  input  rate_cfg_t cfg,
  output logic      tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             at_limit;
  logic             hold_clr;

  assign limit    = CNT_W'(half_cycles(int'(cfg.pre), int'(cfg.sel))) - CNT_W'(1);
  assign at_limit = (cnt >= limit);
  assign hold_clr = !run_en || abort;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (hold_clr)  cnt <= '0;
    else if (at_limit)  cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  assign tick = run_en && !abort && at_limit;

  // R4: each strobe restarts the half period
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
  // R6: a disabled divider is held cleared
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0));
  // R9: an abort clears the count
  p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cnt == '0));
  // R5: the count never exceeds the largest half period
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(half_cycles(7, 7)));
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             master_mode,
  input  logic             run_en,
  output logic             half_tick,
  output logic             xfer_abort
);
  rate_cfg_t cfg;
  logic      abort_w;

  spi_rate_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .master_mode(master_mode), .rd_data(rd_data), .cfg(cfg), .abort_q(abort_w)
  );

  spi_rate_div u_div (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .abort(abort_w),
    .cfg(cfg), .tick(half_tick)
  );

  assign xfer_abort = abort_w;

  // R9: no strobe in the abort cycle
  p_abort_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !half_tick);
endmodule

// File: tb/spi_rate_gen_tb.sv
module spi_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       master_mode = 1'b0;
  logic       run_en = 1'b0;
  logic       half_tick;
  logic       xfer_abort;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int gap = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .master_mode(master_mode), .run_en(run_en), .half_tick(half_tick), .xfer_abort(xfer_abort)
  );

  function automatic int exp_half(input int pre, input int sel);
    int h = pre + 1;
    for (int i = 0; i < sel; i++) h = h * 2;
    return h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures enabled cycles between strobes, compares with queue
  always @(negedge clk) begin
    if (!rst_n || !run_en || xfer_abort) begin
      if (xfer_abort) chk("R9 strobe in abort cycle", int'(half_tick), 0);
      if (rst_n && !run_en) chk("R6 strobe while disabled", int'(half_tick), 0);
      gap = 0;
    end else begin
      gap++;
      if (half_tick) begin
        if (exp_q.size() > 0) chk("R4 strobe spacing", gap, exp_q.pop_front());
        gap = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] d, input logic mst);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d; master_mode = mst;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic run_cfg(input int pre, input int sel, input int n);
    wr(8'((pre << 4) | sel), 1'b0);
    for (int i = 0; i < n; i++) exp_q.push_back(exp_half(pre, sel));
    run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    run_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset abort", int'(xfer_abort), 0);

    // R1: reset setting strobes every enabled cycle
    for (int i = 0; i < 4; i++) exp_q.push_back(1);
    run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(posedge clk); #1 run_en = 1'b0;

    // R2 / R3: field placement and reserved bits
    wr(8'hFF, 1'b0);
    @(negedge clk) chk("R3 reserved read zero", int'(rd_data), 8'h77);
    chk("R8 slave write no abort", int'(xfer_abort), 0);
    wr(8'h25, 1'b0);
    @(negedge clk) chk("R2 readback", int'(rd_data), 8'h25);
    repeat (3) @(negedge clk);
    chk("R10 hold", int'(rd_data), 8'h25);

    // R4: several rates
    run_cfg(0, 1, 3);
    run_cfg(1, 0, 3);
    run_cfg(2, 2, 3);
    run_cfg(4, 3, 2);
    // R5: largest setting
    run_cfg(7, 7, 2);

    // R6: dropping enable mid-count restarts the period
    wr(8'h12, 1'b0);  // H = 2*4 = 8
    run_en = 1'b1;
    repeat (5) @(posedge clk); #1;
    run_en = 1'b0;
    exp_q.push_back(8);
    exp_q.push_back(8);
    @(posedge clk); #1 run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(posedge clk); #1 run_en = 1'b0;

    // R7: master write with changed fields
    wr(8'h30, 1'b1);
    @(negedge clk) chk("R7 abort pulse", int'(xfer_abort), 1);
    @(negedge clk) chk("R7 abort one cycle", int'(xfer_abort), 0);
    // R8: same value in master mode
    wr(8'h30, 1'b1);
    @(negedge clk) chk("R8 unchanged no abort", int'(xfer_abort), 0);
    // R8: changed value in slave mode
    wr(8'h01, 1'b0);
    @(negedge clk) chk("R8 slave change no abort", int'(xfer_abort), 0);

    // R9: abort mid-count clears the divider (H=16 -> H=4)
    wr(8'h13, 1'b0);
    run_en = 1'b1;
    repeat (6) @(posedge clk); #1;
    exp_q.push_back(4);
    exp_q.push_back(4);
    wr_en = 1'b1; wr_data = 8'h11; master_mode = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk) chk("R9 abort seen", int'(xfer_abort), 1);
    wait (exp_q.size() == 0);
    @(posedge clk); #1 run_en = 1'b0; master_mode = 1'b0;
    @(negedge clk) chk("R2 readback after abort", int'(rd_data), 8'h11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule